// File: doc/BRIEF.md
# First-Order Sigma-Delta Pulse-Density DAC

This block turns an unsigned code of `DAC_W` bits into a one-bit pulse stream. Averaged over time, the fraction of clocks on which the output is high equals `code / 2^DAC_W`. The stream is meant to drive an external RC low-pass filter, which recovers a voltage from it. A controller can change the code on any clock. The modulator keeps its internal state across code changes, so the stream continues without restarting.

Inside, a difference stage removes the weight of the bit currently being output from the incoming code. An accumulating register then integrates these differences. The register is two bits wider than the code. Its bit at position `DAC_W` is the output. Because this bit comes straight from the register, the output is glitch-free and changes only on a clock edge.

The integrator produces fixed periodic patterns:
- Midscale toggles on every clock.
- A code whose lowest set bit is at position k repeats every `2^(DAC_W-k)` clocks.
- The codes one step from either rail repeat only once every `2^DAC_W` clocks.

Top module: `dsdac_top`

## Requirements
- R1: While `rst_n` is low the output is low, and the accumulator is cleared asynchronously. Suppose the code is held at midscale `2^(DAC_W-1)` through reset release. Then the outputs seen after the first four rising edges that follow release are 0, 1, 0, 1.
- R2: Take any `2^DAC_W` consecutive output bits produced by updates that all used the same code c. Exactly c of them are 1.
- R3: With the midscale code `2^(DAC_W-1)` applied on two consecutive updates, the output of the second update is the inverse of the first. The output is therefore a square wave of period 2 and duty 1/2.
- R4: Let a nonzero code have its lowest set bit at position k. With that code held, the output is periodic with period `2^(DAC_W-k)`, and it holds `c >> k` ones per period. For `DAC_W = 8`: codes 192, 224, 240 and 248 give periods 4, 8, 16 and 32 with 3, 7, 15 and 31 ones. Codes 64, 32, 16 and 8 give the same periods with a single one.
- R5: Codes 1 and `2^DAC_W - 1` give the longest period, `2^DAC_W` clocks. That period contains a single one or a single zero respectively.
- R6: Any update that uses code 0 produces a low output bit.
- R7: A code change needs no reset. The output bit of the first update that uses the new code already starts a window that satisfies R2.
- R8: The accumulator stays below `2^(DAC_W+1)`, so its top guard bit is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock; each rising edge is one update |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | DAC_W | Unsigned code to convert; sampled on every rising edge |
| bit_o | output | 1 | Registered one-bit pulse stream for the RC filter |

## Verification
Two things can meet in a single update. A new code can arrive on the very edge where the fed-back output is high, so the new code and the subtraction of full-scale weight land in the same addition. The bench provokes this by changing the code back to back: it applies each new code on the clock right after the previous measurement ends, so the change falls at whatever phase the old pattern had reached. Each change is judged by an exact count of ones over the `2^DAC_W` bits that begin at the first update using the new code. The pattern is also checked to repeat at the expected period, and the number of ones within one period is checked.

// File: rtl/dsdac_pkg.sv
package dsdac_pkg;

   // accumulator carries one headroom bit above the output bit and one guard bit
   function automatic int unsigned acc_width(input int unsigned code_w);
      return code_w + 2;
   endfunction

   // full-scale weight of a single output pulse, expressed in code steps
   function automatic longint unsigned pulse_weight(input int unsigned code_w);
      return longint'(1) << code_w;
   endfunction

endpackage

// File: rtl/dsdac_delta.sv
module dsdac_delta #(
   parameter int unsigned DAC_W    = 8,
   parameter bit          CHEAP_FB = 1'b1,
   localparam int unsigned ACC_W   = dsdac_pkg::acc_width(DAC_W)
) (
   input  logic [DAC_W-1:0] code_i,
   input  logic             fb_i,
   output logic [ACC_W-1:0] delta_o
);

   generate
      if (CHEAP_FB) begin : g_concat
         // code < 2^W, so code - 2^W is the code with the two upper bits set
         always_comb begin
            delta_o = fb_i ? {2'b11, code_i} : {2'b00, code_i};
         end
      end else begin : g_subtract
         localparam logic [ACC_W-1:0] WEIGHT = {2'b01, {DAC_W{1'b0}}};
         always_comb begin
            delta_o = {2'b00, code_i} - (fb_i ? WEIGHT : '0);
         end
      end
   endgenerate

endmodule

// File: rtl/dsdac_sigma.sv
module dsdac_sigma #(
   parameter int unsigned DAC_W  = 8,
   localparam int unsigned ACC_W = dsdac_pkg::acc_width(DAC_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] delta_i,
   output logic [ACC_W-1:0] acc_q
);

   logic [ACC_W-1:0] acc_d;

   always_comb begin
      acc_d = acc_q + delta_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else begin
         acc_q <= acc_d;
      end
   end

endmodule

// File: rtl/dsdac_top.sv
module dsdac_top #(
   parameter int unsigned DAC_W    = 8,
   parameter bit          CHEAP_FB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DAC_W-1:0] code_i,
   output logic             bit_o
);

   localparam int unsigned ACC_W = dsdac_pkg::acc_width(DAC_W);

   generate
      if (DAC_W < 2 || DAC_W > 24) begin : g_bad_width
         $error("dsdac_top: DAC_W must lie in 2..24");
      end
   endgenerate

   logic [ACC_W-1:0] delta;
   logic [ACC_W-1:0] acc_q;

   dsdac_delta #(
      .DAC_W   (DAC_W),
      .CHEAP_FB(CHEAP_FB)
   ) u_delta (
      .code_i (code_i),
      .fb_i   (bit_o),
      .delta_o(delta)
   );

   dsdac_sigma #(
      .DAC_W(DAC_W)
   ) u_sigma (
      .clk    (clk),
      .rst_n  (rst_n),
      .delta_i(delta),
      .acc_q  (acc_q)
   );

   // output bit comes straight from the accumulator register
   assign bit_o = acc_q[DAC_W];

endmodule

// File: rtl/dsdac_chk.sv
module dsdac_chk #(
   parameter int unsigned DAC_W  = 8,
   localparam int unsigned ACC_W = DAC_W + 2,
   localparam int unsigned WIN   = 1 << DAC_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DAC_W-1:0] code_i,
   input logic             bit_o,
   input logic [ACC_W-1:0] acc_q
);

   localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

   // window bookkeeping for the density check
   logic [DAC_W-1:0] prev_code;
   logic             prev_live;
   logic [DAC_W-1:0] win_code;
   logic [DAC_W:0]   win_cnt;
   logic [DAC_W:0]   win_ones;
   logic             win_full;
   logic [DAC_W:0]   last_ones;
   logic [DAC_W-1:0] last_code;
   logic [DAC_W:0]   nxt_cnt;
   logic [DAC_W:0]   nxt_ones;

   always_comb begin
      if (win_cnt != '0 && prev_code == win_code) begin
         nxt_cnt  = win_cnt + 1'b1;
         nxt_ones = win_ones + {{DAC_W{1'b0}}, bit_o};
      end else begin
         nxt_cnt  = {{DAC_W{1'b0}}, 1'b1};
         nxt_ones = {{DAC_W{1'b0}}, bit_o};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_code <= '0;
         prev_live <= 1'b0;
         win_code  <= '0;
         win_cnt   <= '0;
         win_ones  <= '0;
         win_full  <= 1'b0;
         last_ones <= '0;
         last_code <= '0;
      end else begin
         prev_code <= code_i;
         prev_live <= 1'b1;
         win_full  <= 1'b0;
         if (prev_live) begin
            win_code <= prev_code;
            if (nxt_cnt == (DAC_W+1)'(WIN)) begin
               win_cnt   <= '0;
               win_ones  <= '0;
               win_full  <= 1'b1;
               last_ones <= nxt_ones;
               last_code <= prev_code;
            end else begin
               win_cnt  <= nxt_cnt;
               win_ones <= nxt_ones;
            end
         end
      end
   end

   AST_RST_LOW: assert property (@(posedge clk) !rst_n |-> !bit_o); // R1

   AST_DENSITY: assert property (@(posedge clk) disable iff (!rst_n)
      win_full |-> last_ones == {1'b0, last_code}); // R2

   AST_MID_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (code_i == MID && $past(code_i) == MID && $past(rst_n)) |=> bit_o != $past(bit_o)); // R3

   AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      code_i == '0 |=> !bit_o); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q[ACC_W-1] == 1'b0); // R8

endmodule

bind dsdac_top dsdac_chk #(.DAC_W(DAC_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .code_i(code_i),
   .bit_o (bit_o),
   .acc_q (acc_q)
);

// File: tb/dsdac_top_tb.sv
`timescale 1ns/1ps
module dsdac_top_tb;

   localparam int W = 8;
   localparam int N = 1 << W;
   localparam int MIDC = N / 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] code_i = W'(MIDC);
   logic         bit_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit ended    = 1'b0;

   typedef struct {
      int    code;
      string tag;
   } item_t;

   item_t sb_q[$];
   int    done_cnt = 0;
   int    pushed   = 0;

   always #4 clk = ~clk;

   dsdac_top #(.DAC_W(W)) u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .code_i(code_i),
      .bit_o (bit_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   function automatic int period_of(input int c);
      int p = N;
      int v = c;
      if (v == 0) return 1;
      while (v % 2 == 0) begin
         v = v / 2;
         p = p / 2;
      end
      return p;
   endfunction

   // driver: applies a code and queues what the monitor must judge
   task automatic apply(input int c, input string tag);
      item_t it;
      code_i = W'(c);
      it.code = c;
      it.tag  = tag;
      sb_q.push_back(it);
      pushed++;
      wait (done_cnt == pushed);
   endtask

   // monitor: collects the stream from the first update using the new code
   initial begin : monitor
      forever begin
         item_t it;
         logic  smp [0:2*N-1];
         int    ones;
         int    p;
         int    mism;
         int    p_ones;
         wait (sb_q.size() > 0);
         it = sb_q.pop_front();
         ones = 0;
         for (int j = 0; j < 2*N; j++) begin
            @(negedge clk);
            smp[j] = bit_o;
         end
         for (int j = 0; j < N; j++) ones += int'(smp[j]);
         p = period_of(it.code);
         mism = 0;
         for (int j = 0; j < N; j++) if (smp[j] !== smp[j+p]) mism++;
         p_ones = 0;
         for (int j = 0; j < p; j++) p_ones += int'(smp[j]);
         check(ones == it.code, {it.tag, " R2 window ones"}, ones, it.code);
         check(mism == 0, {it.tag, " period repeat"}, mism, 0);
         check(p_ones == it.code / (N / p), {it.tag, " ones per period"}, p_ones, it.code / (N / p));
         done_cnt++;
      end
   end

   initial begin : watchdog
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : driver
      int exp_seq [4] = '{0, 1, 0, 1};
      repeat (3) @(negedge clk);
      check(bit_o == 1'b0, "R1 low in reset", int'(bit_o), 0);
      rst_n = 1'b1;
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         check(bit_o == exp_seq[j][0], "R1 first pattern", int'(bit_o), exp_seq[j]);
      end

      apply(MIDC, "R3 midscale");
      apply(192, "R4 192");
      apply(224, "R4 224");
      apply(240, "R4 240");
      apply(248, "R4 248");
      apply(64, "R4 64");
      apply(32, "R4 32");
      apply(16, "R4 16");
      apply(8, "R4 8");
      apply(255, "R5 255");
      apply(1, "R5 1");
      apply(0, "R6 zero");
      apply(100, "R2 code 100");
      apply(200, "R7 before change");
      apply(37, "R7 after change");
      apply(MIDC + 1, "R7 odd near mid");

      // asynchronous reset in mid-stream (R1)
      code_i = W'(255);
      repeat (5) @(negedge clk);
      code_i = W'(MIDC);
      rst_n = 1'b0;
      #1;
      check(bit_o == 1'b0, "R1 async clear", int'(bit_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int j = 0; j < 4; j++) begin
         @(negedge clk);
         check(bit_o == exp_seq[j][0], "R1 pattern after re-reset", int'(bit_o), exp_seq[j]);
      end
      summary();
   end

endmodule